// File: doc/BRIEF.md
# Boot-Time Serial Configuration Loader

This block fetches a fixed-length configuration word over a slow serial link as soon as the power-good input reports that supplies are stable. It divides the master clock to make a serial clock for an external source, such as a small serial memory or a few gates of glue logic. On each rising edge of that serial clock it takes one data bit, and it keeps doing so until 256 bits have arrived. The assembled word then appears on a parallel output together with a valid flag. Other logic on the chip decodes the individual mode fields from that word.

After the word is complete, the serial clock keeps toggling, but no more data is taken. If power-good drops, or reset is applied, everything clears, and the next rise of power-good starts a fresh load from the first bit. Power-good is taken to be synchronous to the master clock, so any synchronizer sits upstream.

Top module: `boot_mode_loader`

## Requirements
- R1: While pwr_good_i is high, ser_clk_o has a period of 256 master cycles: it is high for 128 cycles and then low for 128 cycles. While pwr_good_i is low, ser_clk_o is held low.
- R2: The first rising edge of ser_clk_o comes on the 128th rising master edge at which pwr_good_i is sampled high.
- R3: Each data bit is taken from ser_data_i at the master edge on which ser_clk_o goes from 0 to 1. The value that ser_data_i holds while ser_clk_o is high is never stored.
- R4: Bits are numbered from 0 in the order they arrive, and bit n is placed in cfg_word_o[n]. The first bit lands in position 0 and the 256th bit lands in position 255.
- R5: Only the first 256 bits after power-good asserts are stored. Later activity on ser_data_i has no effect on cfg_word_o.
- R6: ser_clk_o keeps toggling with the period of R1 after cfg_valid_o is set.
- R7: cfg_valid_o goes high one master cycle after the edge that captures the 256th bit, which is one cycle after the 256th rise of ser_clk_o. It stays high until pwr_good_i is low or rst_n_i is low at a clock edge.
- R8: cfg_word_o is all zeros whenever cfg_valid_o is low, so a partly loaded word is never visible.
- R9: When pwr_good_i is low at a clock edge, the divider, the bit count, cfg_valid_o and cfg_word_o all clear. The next load then starts again from bit 0.
- R10: When rst_n_i is low at a clock edge, ser_clk_o, cfg_valid_o and cfg_word_o are all zero in the following cycle, whatever the state of pwr_good_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| pwr_good_i | input | 1 | Supplies stable; a rise starts a load, and low clears the block |
| ser_data_i | input | 1 | Serial configuration data from the external source |
| ser_clk_o | output | 1 | Divided serial clock sent to the source |
| cfg_word_o | output | NUM_BITS (256) | Loaded configuration word, zero until valid |
| cfg_valid_o | output | 1 | Configuration word is complete |

## Verification
The assertions check the following on every cycle:
- the serial clock's half-period and the fact that it never stalls;
- the zero word while the valid flag is low;
- that the word is frozen once it is valid;
- the clearing caused by a low power-good;
- that the valid flag rises only after exactly 256 serial-clock rises.

Only the bench scenarios can show the bit ordering and the sampling point. The bench drives the inverse of each bit while the serial clock is high and the correct bit only while it is low. It also checks that the first rise arrives 128 cycles after power-good, and that an aborted partial load leaves nothing behind for the next full load, including the end positions 0 and 255.

// File: rtl/bml_pkg.sv
// Package: shared types and helpers for the boot-time serial loader.
// Assumes: nothing beyond IEEE 1800-2017 elaboration semantics.
package bml_pkg;

    // Loader phases: off (power not good), shifting, word complete
    typedef enum logic [1:0] {
        LD_OFF   = 2'd0,
        LD_SHIFT = 2'd1,
        LD_DONE  = 2'd2
    } ld_state_e;

    // True when v is a non-zero power of two
    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/bml_clk_div.sv
// Module: bml_clk_div
// Divides the master clock by CLK_DIV to make a 50% duty serial clock.
// It also gives a one-cycle strobe on the master cycle whose closing
// edge raises the serial clock.
// Assumes: CLK_DIV is even and at least 2, and run_i is synchronous.
module bml_clk_div #(
    parameter int unsigned CLK_DIV = 256
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o
);

    localparam int unsigned HALF  = CLK_DIV / 2;
    localparam int unsigned CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] RISE_AT = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] HALF_V  = CNT_W'(HALF);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             sclk_q;

    // Next count: a power-of-two divider wraps on its own, any other value compares
    generate
        if (bml_pkg::is_pow2(CLK_DIV)) begin : g_wrap_free
            always_comb cnt_nxt = cnt_q + 1'b1;
        end else begin : g_wrap_cmp
            always_comb cnt_nxt = (cnt_q == CNT_W'(CLK_DIV - 1)) ? '0 : cnt_q + 1'b1;
        end
    endgenerate

    // Phase counter and registered serial clock, both cleared when not running
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || !run_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            sclk_q <= (cnt_nxt >= HALF_V);
        end
    end

    // Strobe in the cycle whose closing edge takes the serial clock high
    always_comb rise_o = rst_n_i && run_i && (cnt_q == RISE_AT);

    assign sclk_o = sclk_q;

endmodule

// File: rtl/bml_shift_in.sv
// Module: bml_shift_in
// Collects NUM_BITS serial bits, first arrival at index 0, and stops
// once full. It shifts right, with each new bit entering at the top.
// Assumes: take_i is a single-cycle strobe, and run_i low clears it.
module bml_shift_in #(
    parameter int unsigned NUM_BITS = 256
) (
    input  logic                clk_i,
    input  logic                rst_n_i,
    input  logic                run_i,
    input  logic                take_i,
    input  logic                sdata_i,
    output logic [NUM_BITS-1:0] word_o,
    output logic                full_o
);

    localparam int unsigned BCNT_W = $clog2(NUM_BITS + 1);
    localparam logic [BCNT_W-1:0] LAST = BCNT_W'(NUM_BITS);

    logic [NUM_BITS-1:0] word_q;
    logic [NUM_BITS-1:0] word_nxt;
    logic [BCNT_W-1:0]   cnt_q;

    // Shift path: one bit wide is a plain load, wider shifts towards bit 0
    generate
        if (NUM_BITS == 1) begin : g_single
            always_comb word_nxt = sdata_i;
        end else begin : g_shift
            always_comb word_nxt = {sdata_i, word_q[NUM_BITS-1:1]};
        end
    endgenerate

    // Capture one bit per strobe until the count reaches NUM_BITS
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || !run_i) begin
            word_q <= '0;
            cnt_q  <= '0;
        end else if (take_i && !full_o) begin
            word_q <= word_nxt;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Full once the last bit has been stored
    always_comb full_o = (cnt_q == LAST);

    assign word_o = word_q;

endmodule

// File: rtl/bml_cfg_hold.sv
// Module: bml_cfg_hold
// Sequences the load and holds the finished word. It enables capture
// until the word is complete, then copies it to a zero-initialised
// output register one cycle after the last bit.
// Assumes: full_i is registered upstream and stays high until cleared.
module bml_cfg_hold #(
    parameter int unsigned NUM_BITS = 256
) (
    input  logic                clk_i,
    input  logic                rst_n_i,
    input  logic                run_i,
    input  logic                full_i,
    input  logic [NUM_BITS-1:0] word_i,
    output logic                take_en_o,
    output logic [NUM_BITS-1:0] cfg_o,
    output logic                valid_o
);

    import bml_pkg::*;

    ld_state_e           state_q;
    logic [NUM_BITS-1:0] cfg_q;

    // Phase sequencing and copying of the completed word
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || !run_i) begin
            state_q <= LD_OFF;
            cfg_q   <= '0;
        end else begin
            unique case (state_q)
                LD_OFF:   state_q <= LD_SHIFT;
                LD_SHIFT: begin
                    if (full_i) begin
                        state_q <= LD_DONE;
                        cfg_q   <= word_i;
                    end
                end
                LD_DONE:  state_q <= LD_DONE;
                default:  state_q <= LD_OFF;
            endcase
        end
    end

    // Capture is allowed until the word is complete
    always_comb take_en_o = run_i && (state_q != LD_DONE);

    // Valid flag decoded from the phase
    always_comb valid_o = (state_q == LD_DONE);

    assign cfg_o = cfg_q;

endmodule

// File: rtl/boot_mode_loader.sv
// Module: boot_mode_loader (top)
// Loads a NUM_BITS configuration word serially after power-good, using
// a serial clock of clk_i / CLK_DIV that keeps running after the load.
// Assumes: pwr_good_i is synchronous to clk_i, and rst_n_i is
// synchronous and active low.
module boot_mode_loader #(
    parameter int unsigned CLK_DIV  = 256,
    parameter int unsigned NUM_BITS = 256
) (
    input  logic                clk_i,
    input  logic                rst_n_i,
    input  logic                pwr_good_i,
    input  logic                ser_data_i,
    output logic                ser_clk_o,
    output logic [NUM_BITS-1:0] cfg_word_o,
    output logic                cfg_valid_o
);

    logic                rise_w;
    logic                take_en_w;
    logic                full_w;
    logic [NUM_BITS-1:0] word_w;

    // Serial clock generation
    bml_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .run_i   (pwr_good_i),
        .sclk_o  (ser_clk_o),
        .rise_o  (rise_w)
    );

    // Bit collection on serial-clock rising edges
    bml_shift_in #(.NUM_BITS(NUM_BITS)) u_shift (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .run_i   (pwr_good_i),
        .take_i  (rise_w && take_en_w),
        .sdata_i (ser_data_i),
        .word_o  (word_w),
        .full_o  (full_w)
    );

    // Sequencing and the output hold register
    bml_cfg_hold #(.NUM_BITS(NUM_BITS)) u_hold (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .run_i     (pwr_good_i),
        .full_i    (full_w),
        .word_i    (word_w),
        .take_en_o (take_en_w),
        .cfg_o     (cfg_word_o),
        .valid_o   (cfg_valid_o)
    );

endmodule

// File: rtl/bml_checker.sv
// Module: bml_checker
// Property checker for boot_mode_loader, bound to every instance of it.
// It tracks the serial clock's run lengths and rise count in its own
// counters.
// Assumes: the same parameters as the top it is bound to.
module bml_checker #(
    parameter int unsigned CLK_DIV  = 256,
    parameter int unsigned NUM_BITS = 256
) (
    input logic                clk_i,
    input logic                rst_n_i,
    input logic                pwr_good_i,
    input logic                ser_clk_o,
    input logic                cfg_valid_o,
    input logic [NUM_BITS-1:0] cfg_word_o
);

    localparam int unsigned HALF  = CLK_DIV / 2;
    localparam int unsigned RUN_W = $clog2(HALF + 2);
    localparam int unsigned RIS_W = $clog2(NUM_BITS + 2);
    localparam logic [RUN_W-1:0] HALF_V  = RUN_W'(HALF);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(HALF + 1);
    localparam logic [RIS_W-1:0] NB_V    = RIS_W'(NUM_BITS);
    localparam logic [RIS_W-1:0] RIS_SAT = RIS_W'(NUM_BITS + 1);

    logic             prev_q;
    logic             seen_q;
    logic [RUN_W-1:0] run_q;
    logic [RIS_W-1:0] rises_q;

    // Track the serial clock's previous level, run length and rising edges
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || !pwr_good_i) begin
            prev_q  <= 1'b0;
            seen_q  <= 1'b0;
            run_q   <= RUN_W'(1);
            rises_q <= '0;
        end else begin
            prev_q <= ser_clk_o;
            if (ser_clk_o != prev_q) begin
                run_q  <= RUN_W'(1);
                seen_q <= 1'b1;
            end else if (run_q != RUN_SAT) begin
                run_q <= run_q + 1'b1;
            end
            if (ser_clk_o && !prev_q && rises_q != RIS_SAT)
                rises_q <= rises_q + 1'b1;
        end
    end

    // R1: each completed level of the serial clock lasts exactly HALF cycles
    a_r1_half_period: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (pwr_good_i && seen_q && (ser_clk_o != prev_q)) |-> (run_q == HALF_V));

    // R6: the serial clock never stays at one level beyond HALF cycles
    a_r6_clock_keeps_running: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (pwr_good_i && seen_q) |-> (run_q <= HALF_V));

    // R7: valid rises only after exactly NUM_BITS serial-clock rises
    a_r7_valid_after_last_bit: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(cfg_valid_o) |-> (rises_q == NB_V));

    // R8: no partial word is visible
    a_r8_zero_until_valid: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !cfg_valid_o |-> (cfg_word_o == '0));

    // R5: a completed word stays frozen while power stays good
    a_r5_word_frozen: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (cfg_valid_o && pwr_good_i) |=> (cfg_valid_o && $stable(cfg_word_o)));

    // R9: power-good low clears the serial clock and the valid flag
    a_r9_power_drop_clears: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !pwr_good_i |=> (!ser_clk_o && !cfg_valid_o));

endmodule

bind boot_mode_loader bml_checker #(
    .CLK_DIV  (CLK_DIV),
    .NUM_BITS (NUM_BITS)
) u_bml_checker (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .pwr_good_i  (pwr_good_i),
    .ser_clk_o   (ser_clk_o),
    .cfg_valid_o (cfg_valid_o),
    .cfg_word_o  (cfg_word_o)
);

// File: tb/tb_boot_mode_loader.sv
// Bench for boot_mode_loader: a serial source model driven from tasks,
// random words from a fixed seed, and directed abort, end-bit and reset cases.
module tb_boot_mode_loader;

    localparam int NB   = 256;
    localparam int DIV  = 256;
    localparam int HALF = DIV / 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pwr_good;
    logic          sdata;
    logic          sclk;
    logic          valid;
    logic [NB-1:0] cfg;

    int checks   = 0;
    int fails    = 0;
    bit finished = 0;
    int seed_tmp;

    always #10 clk = ~clk;

    boot_mode_loader #(.CLK_DIV(DIV), .NUM_BITS(NB)) dut (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .pwr_good_i  (pwr_good),
        .ser_data_i  (sdata),
        .ser_clk_o   (sclk),
        .cfg_word_o  (cfg),
        .cfg_valid_o (valid)
    );

    // Count one check and report it on a mismatch
    task automatic chk(input string req, input string what,
                       input logic [NB-1:0] act, input logic [NB-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Random word built from the seeded generator
    function automatic logic [NB-1:0] rand_word();
        logic [NB-1:0] w;
        for (int i = 0; i < NB / 32; i++) w[i*32 +: 32] = $urandom;
        return w;
    endfunction

    // Expected serial-clock rises in a window of whole periods
    function automatic int rises_in_window(input int cycles);
        return cycles / DIV;
    endfunction

    // Raise power-good, then act as the serial source until stop_at rises
    task automatic load(input logic [NB-1:0] pat, input int stop_at, input bit full);
        int rises = 0, waitc = 0, run = 0, bad_run = 0, bad_zero = 0, first_at = -1;
        int post_rises = 0, post_bad = 0;
        bit seen = 0;
        logic prev_s;
        @(negedge clk);
        sdata    = pat[0];
        pwr_good = 1'b1;
        prev_s   = 1'b0;
        while (rises < stop_at) begin
            @(negedge clk);
            waitc++;
            if (!valid && cfg !== '0) bad_zero++;
            if (sclk !== prev_s) begin
                if (seen && run != HALF) bad_run++;
                seen = 1;
                run  = 1;
                if (sclk) begin
                    rises++;
                    if (first_at < 0) first_at = waitc;
                    if (rises == NB && full) chk("R7", "valid in last-rise cycle", valid, 0);
                    // R3: drive the wrong value while the serial clock is high
                    sdata = (rises < NB) ? ~pat[rises] : 1'($urandom);
                end else if (rises < NB) begin
                    sdata = pat[rises];
                end
            end else begin
                run++;
            end
            prev_s = sclk;
        end
        chk("R2", "first rise delay", first_at, HALF);
        chk("R1", "half-period errors", bad_run, 0);
        chk("R8", "partial word visible", bad_zero, 0);
        if (full) begin
            @(negedge clk);
            chk("R7", "valid one cycle after last rise", valid, 1);
            chk("R4", "word order (R3 sampling)", cfg, pat);
            // R5/R6: random data after completion, with the clock still watched
            for (int c = 0; c < 4 * DIV; c++) begin
                sdata = 1'($urandom);
                @(negedge clk);
                if (sclk && !prev_s) post_rises++;
                if (cfg !== pat || valid !== 1'b1) post_bad++;
                prev_s = sclk;
            end
            chk("R5", "word changed after completion", post_bad, 0);
            chk("R6", "rises after completion", post_rises, rises_in_window(4 * DIV));
        end
    endtask

    initial begin
        logic [NB-1:0] pat1, pat2, junk;
        seed_tmp = $urandom(32'd1357);
        rst_n    = 1'b0;
        pwr_good = 1'b0;
        sdata    = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10", "reset sclk", sclk, 0);
        chk("R10", "reset valid", valid, 0);
        chk("R10", "reset word", cfg, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9", "sclk idle without power-good", sclk, 0);

        pat1 = rand_word();
        load(pat1, NB, 1);

        pwr_good = 1'b0;
        @(negedge clk);
        chk("R9", "valid after drop", valid, 0);
        chk("R9", "word after drop", cfg, 0);
        chk("R9", "sclk after drop", sclk, 0);

        junk = rand_word();
        load(junk, 20, 0);
        pwr_good = 1'b0;
        @(negedge clk);
        chk("R9", "sclk after abort", sclk, 0);
        repeat (4) @(negedge clk);

        // End positions 0 and 255 directed, the rest random
        pat2 = rand_word();
        pat2[0]    = 1'b1;
        pat2[1]    = 1'b0;
        pat2[NB-2] = 1'b0;
        pat2[NB-1] = 1'b1;
        load(pat2, NB, 1);

        rst_n = 1'b0;
        @(negedge clk);
        chk("R10", "reset valid with power good", valid, 0);
        chk("R10", "reset word with power good", cfg, 0);
        chk("R10", "reset sclk with power good", sclk, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog: actual=not complete expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule